// File: doc/BRIEF.md
# PLL Divider Pair Search Engine

This block chooses the feedback divider M, the reference divider N and a power-of-two post-divider exponent k for a clock synthesizer. The caller gives a wanted output frequency in units of 0.01 MHz. The block then tries every M/N pair allowed by the synthesizer. For each pair it computes the output the synthesizer would produce from a 14.31818 MHz reference, in 8-bit fixed point. It keeps the pair whose output lies closest to the request.

A search begins with a one-cycle `start` pulse while the block is idle. `busy` stays high while the grid is walked. The result is a packed 16-bit program word, presented with a one-cycle `done` pulse. A single narrow restoring divider is shared by all candidates. It retires `RB` quotient bits per clock, so each candidate costs a fixed small number of cycles. A zero request is answered at once with a fixed code and no search.

Top module: `pll_pair_search`

## Requirements
- R1: After reset `busy` and `done` are low and `word` is 0x0000.
- R2: A start with `freq_req` equal to 0 runs no search. On the next clock edge, `word` becomes 0xE0 with a one-cycle `done` pulse, and `busy` stays low.
- R3: A non-zero request below 8000 is treated as 8000, and one above 15938 is treated as 15938. A clamped request yields the same word as its limit value.
- R4: The exponent k is the smallest count of doublings that brings the clamped request to at least 64000. It is placed at bits 7:6 of the word.
- R5: The word equals N·256 + k·64 + M. M takes values 2 to 30 in the outer loop, and N takes values 35 to 247 in the inner loop. M occupies bits 4:0 and N occupies bits 15:8.
- R6: The target is floor(f·256/100), taken from the clamped request before any doubling. Each candidate output is floor(938356·(N+8) / (2^k·256·(M+2))).
- R7: The chosen pair has the smallest absolute error. The best error starts at all ones, and a candidate replaces the best only when its error is strictly smaller, so on a tie the earliest pair wins. The best error never grows during a search.
- R8: `busy` is high from the clock edge that accepts a non-zero start until the edge that delivers the result. `word` does not change while `busy` stays high.
- R9: `done` is a single-cycle pulse and is never high together with `busy`.
- R10: A start pulse while `busy` is high is ignored, and the running search finishes with its original request.
- R11: Outside a search, `word` holds its last result until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe, taken only while idle |
| freq_req | input | 16 | Wanted frequency in 0.01 MHz units |
| busy | output | 1 | High while the grid is being searched |
| done | output | 1 | One-cycle pulse marking a new `word` |
| word | output | 16 | Packed program word |

## Verification
The assertions assume that `freq_req` matters only in the cycle a start is accepted, and that a start arriving during a search has no effect. They do not assume anything about how often `start` is pulsed. The stimulus changes inputs only on the falling clock edge and holds `start` for exactly one cycle. It injects one stray start, with a different request, in the middle of a search. Every search waits for `done` before the next request is issued.

// File: rtl/pll_pair_search.sv
module pll_pair_search #(
  parameter int REF_SCALED = 938356,
  parameter int F_MIN      = 8000,
  parameter int F_MAX      = 15938,
  parameter int M_MIN      = 2,
  parameter int M_MAX      = 30,
  parameter int N_MIN      = 35,
  parameter int N_MAX      = 247,
  parameter int RB         = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] freq_req,
  output logic        busy,
  output logic        done,
  output logic [15:0] word
);
  localparam int ACC_W = $clog2(REF_SCALED * (N_MAX + 8) + 1);
  localparam int DW    = ACC_W - 8;
  localparam int ITER  = (DW + RB - 1) / RB;
  localparam int DWP   = ITER * RB;
  localparam int DV_W  = $clog2(M_MAX + 3);
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [ACC_W-1:0] ACC_FIRST = ACC_W'(REF_SCALED * (N_MIN + 8));

  logic [4:0]       m_q, bm_q;
  logic [7:0]       n_q, bn_q;
  logic [1:0]       k_q;
  logic [31:0]      tgt_q, best_q;
  logic [ACC_W-1:0] acc_q;
  logic [DWP-1:0]   sh_q;
  logic [DV_W:0]    rem_q;
  logic [CNT_W-1:0] cnt_q;

  // request conditioning at start
  logic [31:0] f_cl, f_dbl;
  logic [1:0]  k_new;
  always_comb begin
    f_cl = 32'(freq_req);
    if (f_cl < F_MIN) f_cl = F_MIN;
    if (f_cl > F_MAX) f_cl = F_MAX;
    f_dbl = f_cl;
    k_new = 2'd0;
    for (int i = 0; i < 3; i++) begin
      if (f_dbl < 32'(F_MIN * 8)) begin
        f_dbl = f_dbl << 1;
        k_new = k_new + 2'd1;
      end
    end
  end

  // shared divider: RB restoring steps per cycle
  logic [DV_W:0]  dvs, r_nx;
  logic [DWP-1:0] s_nx;
  assign dvs = (DV_W+1)'(m_q) + (DV_W+1)'(2);
  always_comb begin
    r_nx = rem_q;
    s_nx = sh_q;
    for (int i = 0; i < RB; i++) begin
      r_nx = {r_nx[DV_W-1:0], s_nx[DWP-1]};
      s_nx = {s_nx[DWP-2:0], 1'b0};
      if (r_nx >= dvs) begin
        r_nx  = r_nx - dvs;
        s_nx[0] = 1'b1;
      end
    end
  end

  logic        last_div, last_n, last_pair, better;
  logic [31:0] q32, err;
  logic [4:0]  bm_nx;
  logic [7:0]  bn_nx;
  logic [ACC_W-1:0] acc_nx;
  assign last_div  = (cnt_q == CNT_W'(ITER - 1));
  assign last_n    = (n_q == 8'(N_MAX));
  assign last_pair = last_n && (m_q == 5'(M_MAX));
  assign q32       = 32'(s_nx);
  assign err       = (q32 > tgt_q) ? q32 - tgt_q : tgt_q - q32;
  assign better    = err < best_q;
  assign bm_nx     = better ? m_q : bm_q;
  assign bn_nx     = better ? n_q : bn_q;
  assign acc_nx    = last_n ? ACC_FIRST : acc_q + ACC_W'(REF_SCALED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; word <= '0;
      m_q <= '0; n_q <= '0; k_q <= '0; bm_q <= '0; bn_q <= '0;
      tgt_q <= '0; best_q <= '1; acc_q <= '0; sh_q <= '0; rem_q <= '0; cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (freq_req == 16'd0) begin
            word <= 16'h00E0;
            done <= 1'b1;
          end else begin
            busy   <= 1'b1;
            k_q    <= k_new;
            tgt_q  <= (f_cl * 32'd256) / 32'd100;
            m_q    <= 5'(M_MIN);
            n_q    <= 8'(N_MIN);
            acc_q  <= ACC_FIRST;
            sh_q   <= DWP'(ACC_FIRST >> (8 + int'(k_new)));
            rem_q  <= '0;
            cnt_q  <= '0;
            best_q <= '1;
          end
        end
      end else if (!last_div) begin
        sh_q  <= s_nx;
        rem_q <= r_nx;
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        if (better) best_q <= err;
        bm_q <= bm_nx;
        bn_q <= bn_nx;
        if (last_pair) begin
          busy <= 1'b0;
          done <= 1'b1;
          word <= (16'(bn_nx) << 8) + (16'(k_q) << 6) + 16'(bm_nx);
        end else begin
          if (last_n) begin
            m_q <= m_q + 5'd1;
            n_q <= 8'(N_MIN);
          end else begin
            n_q <= n_q + 8'd1;
          end
          acc_q <= acc_nx;
          sh_q  <= DWP'(acc_nx >> (8 + int'(k_q)));
          rem_q <= '0;
          cnt_q <= '0;
        end
      end
    end
  end

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(word));
  a_r5_grid_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (m_q >= 5'(M_MIN) && m_q <= 5'(M_MAX) && n_q >= 8'(N_MIN) && n_q <= 8'(N_MAX)));
  a_r7_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> best_q <= $past(best_q));
  a_r5_word_n_field: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word == 16'h00E0 || (word[15:8] >= 8'(N_MIN) && word[15:8] <= 8'(N_MAX))));
  a_r10_busy_keeps_k: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(k_q) && $stable(tgt_q));
endmodule

// File: tb/pll_pair_search_tb_top.sv
module pll_pair_search_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] freq_req = '0;
  logic busy, done;
  logic [15:0] word;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pll_pair_search dut_i (.clk(clk), .rst_n(rst_n), .start(start), .freq_req(freq_req),
                         .busy(busy), .done(done), .word(word));

  localparam int NV = 4;
  localparam int VEC_F [NV] = '{12345, 8000, 65535, 100};
  localparam int VEC_L [NV] = '{12345, 8000, 15938, 8000};

  function automatic logic [15:0] ref_word(int f_in);
    longint f, tgt, fo, d, best, ff;
    int k, bm, bn;
    if (f_in == 0) return 16'h00E0;
    f = f_in;
    if (f < 8000) f = 8000;
    if (f > 15938) f = 15938;
    tgt = f * 256 / 100;
    k = 0; ff = f;
    while (ff < 64000) begin ff = ff * 2; k++; end
    best = 64'hFFFFFFFF; bm = 0; bn = 0;
    for (int m = 2; m <= 30; m++)
      for (int n = 35; n <= 247; n++) begin
        fo = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
        d = (fo > tgt) ? fo - tgt : tgt - fo;
        if (d < best) begin best = d; bm = m; bn = n; end
      end
    return 16'((bn << 8) + (k << 6) + bm);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // start a search; optionally inject a stray start mid-search (R10)
  task automatic run(int f, bit stray, output logic [15:0] res);
    int cyc;
    @(negedge clk);
    freq_req = 16'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0; freq_req = 16'h1234;
    check(busy === 1'b1, "R8 busy after start", int'(busy), 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 40000) begin
      if (stray && cyc == 100) begin
        start = 1'b1; freq_req = 16'd8000;
      end else begin
        start = 1'b0;
      end
      if (busy !== 1'b1) check(0, "R8 busy dropped early", int'(busy), 1);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R9 done without busy", int'({done, busy}), 2);
    res = word;
    @(negedge clk);
    check(done === 1'b0, "R9 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] r;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 flags after reset", int'({busy, done}), 0);
    check(word === 16'h0000, "R1 word after reset", int'(word), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      e = ref_word(VEC_L[i]);
      run(VEC_F[i], 1'b0, r);
      check(r === e, "R6 R7 best pair", int'(r), int'(e));
      check(r[7:6] === 2'd3, "R4 exponent field", int'(r[7:6]), 3);
      check(r[4:0] >= 5'd2 && r[4:0] <= 5'd30 && r[15:8] >= 8'd35 && r[15:8] <= 8'd247,
            "R5 field ranges", int'(r), int'(e));
      if (VEC_F[i] != VEC_L[i]) check(r === ref_word(VEC_L[i]), "R3 clamped matches limit", int'(r), int'(e));
    end

    e = ref_word(15938);
    run(15938, 1'b1, r);
    check(r === e, "R10 stray start ignored", int'(r), int'(e));

    repeat (10) @(negedge clk);
    check(word === e && done === 1'b0, "R11 word held idle", int'(word), int'(e));

    @(negedge clk);
    freq_req = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(word === 16'h00E0, "R2 zero word", int'(word), 32'hE0);
    check(done === 1'b1 && busy === 1'b0, "R2 zero done no busy", int'({done, busy}), 2);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R2 no search after zero", int'({done, busy}), 0);

    summary();
  end
endmodule